// File: doc/BRIEF.md
# Descriptor Ring Source Fetcher

This block is the sending half of a descriptor-driven copy engine. Software builds transmit descriptors in a circular ring in memory and moves a write index forward. The engine walks the ring in order. It reads each descriptor through a synchronous descriptor RAM port and turns it into a segment on a stream output. Each segment carries the buffer address, the byte count, a beat count and a transfer tag. A hardware read index tells software how far the engine has got.

A descriptor can ask to be chained with the ones after it. A run of chained descriptors closed by an unchained one forms one transfer, and that transfer produces a single completion pulse carrying the combined byte count. The read index moves over the whole run only once its closing segment has been accepted downstream.

The ring holds a power-of-two number of entries. One slot always stays empty, so a full ring and an empty ring never look alike. The block reports the free slot count and two programmable fill watermarks. A byte count above the programmed limit is clamped, recorded in a sticky error flag, and the descriptor is still retired.

Top module: `srcring_fetcher`

## Requirements
- R1: The ring holds 2^L entries, where L is written at register address 1 and clamped to IDX_W; L resets to IDX_W. Every index is kept modulo the entry count. Writing address 1 restarts the read, fetch and write indices at 0.
- R2: A descriptor is fetched only while the next fetch index differs from the write index, which is written at address 2. Fetches go in strict ring order, one RAM read per descriptor, at address base + 8 × index. The base is written at address 0.
- R3: Descriptor word layout: bits 31:0 hold the buffer address, bits 47:32 the byte count and bits 63:48 the flags. Flag bit 0 marks a chained descriptor, flag bit 1 requests byte swap, and flag bits 15:2 hold the transfer tag. The segment shows the address and tag unchanged.
- R4: Each descriptor yields one segment with beats = ceil(bytes / 8). Its fields hold steady while out_valid is high and out_ready is low.
- R5: out_last is low for a chained descriptor and high for the closing one. Exactly one done pulse follows each closing segment, one cycle after its acceptance. The pulse carries the sum of the run's segment byte counts and the closing descriptor's tag.
- R6: hw_rd_idx changes only in the cycle after a closing segment is accepted, and then it steps by the number of descriptors in the run.
- R7: free_slots = (rd − wr − 1) mod entries, so at most entries − 1 descriptors are ever outstanding.
- R8: The control register at address 3 holds the byte limit (bits 15:0, reset 0xFFFF). A descriptor above the limit streams with its byte count clamped to the limit. err_oversize sets when such a segment is accepted and clears on a control-register write.
- R9: out_swap is the descriptor's swap flag OR the ring swap enable (control bit 16).
- R10: Let pending = (wr − rd) mod entries. wm_low_hit = pending ≤ low and wm_high_hit = pending ≥ high. Both marks are written at address 4 (low in bits 15:0, high in bits 31:16) and reset to 0 and 2^IDX_W.
- R11: After reset the read index is 0, and no segment, done pulse, error or descriptor read is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| desc_rd_en | output | 1 | Descriptor RAM read request |
| desc_rd_addr | output | 32 | Descriptor byte address |
| desc_rd_data | input | 64 | Descriptor word, valid the cycle after a read |
| out_valid | output | 1 | Segment valid |
| out_ready | input | 1 | Segment accepted when high with out_valid |
| out_addr | output | 32 | Segment buffer address |
| out_bytes | output | 16 | Segment byte count (after clamping) |
| out_beats | output | 14 | Segment beat count |
| out_id | output | 14 | Transfer tag |
| out_swap | output | 1 | Byte-swap request |
| out_last | output | 1 | Closing segment of a transfer |
| done | output | 1 | Transfer completion pulse |
| done_bytes | output | 20 | Total bytes of the completed transfer |
| done_id | output | 14 | Tag of the completed transfer |
| hw_rd_idx | output | 4 | Hardware read index |
| free_slots | output | 4 | Descriptors software may still add |
| wm_low_hit | output | 1 | Fill at or below low mark |
| wm_high_hit | output | 1 | Fill at or above high mark |
| err_oversize | output | 1 | Sticky oversize flag |

## Verification
The in-RTL assertions check on every cycle the protocol rules that do not depend on data. A stalled segment holds steady, only one RAM read is issued per descriptor, and the read index and done pulse move only after a closing acceptance or a restart. The error flag stays sticky, and the write index stays inside the ring. The bench scenarios are needed for the rest. They show that descriptors come out in ring order with the right addresses and fields, and that chained runs sum their bytes correctly. They also cover the read index jump across the ring wrap on a small ring, clamping against the byte limit, and watermark thresholds reached while the stream is stalled.

// File: rtl/srcring_pkg.sv
package srcring_pkg;

  // descriptor word: flags in the top half-word, byte count below, address at the bottom
  typedef struct packed {
    logic [15:0] flags;
    logic [15:0] nbytes;
    logic [31:0] addr;
  } desc_t;

  localparam int unsigned DESC_LG   = 3;   // 8-byte descriptors
  localparam int unsigned FLG_CHAIN = 0;
  localparam int unsigned FLG_SWAP  = 1;
  localparam int unsigned FLG_ID_LO = 2;
  localparam int unsigned ID_W      = 16 - FLG_ID_LO;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_SEND} eng_state_t;

  typedef enum logic [2:0] {
    RA_BASE  = 3'd0,
    RA_SIZE  = 3'd1,
    RA_WRIDX = 3'd2,
    RA_CTRL  = 3'd3,
    RA_WMARK = 3'd4
  } reg_addr_t;

  // index i advanced by n inside a ring described by mask
  function automatic logic [15:0] ring_step(input logic [15:0] i, input logic [15:0] n,
                                            input logic [15:0] mask);
    return (i + n) & mask;
  endfunction

  // entries from b forward to a
  function automatic logic [15:0] ring_dist(input logic [15:0] a, input logic [15:0] b,
                                            input logic [15:0] mask);
    return (a - b) & mask;
  endfunction

  // slots the producer may still fill, keeping one empty
  function automatic logic [15:0] ring_room(input logic [15:0] rd, input logic [15:0] wr,
                                            input logic [15:0] mask);
    return (rd - wr - 16'd1) & mask;
  endfunction

  function automatic logic [16:0] beats_of(input logic [15:0] n, input int unsigned lg);
    logic [16:0] s;
    s = {1'b0, n} + 17'((32'd1 << lg) - 32'd1);
    return s >> lg;
  endfunction

endpackage

// File: rtl/srcring_regs.sv
module srcring_regs
  import srcring_pkg::*;
#(
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      ring_base,
  output logic [IDX_W-1:0] ring_mask,
  output logic [IDX_W-1:0] wr_idx,
  output logic [15:0]      max_len,
  output logic             swap_en,
  output logic [IDX_W:0]   wm_low,
  output logic [IDX_W:0]   wm_high,
  output logic             restart,
  output logic             ctrl_wr
);

  localparam int unsigned LG_W = $clog2(IDX_W + 1);

  logic [LG_W-1:0] size_lg;
  logic [LG_W-1:0] lg_wr;

  assign lg_wr     = (reg_wdata > 32'(IDX_W)) ? LG_W'(IDX_W) : reg_wdata[LG_W-1:0];
  assign ring_mask = IDX_W'({IDX_W{1'b1}} >> (IDX_W - 32'(size_lg)));
  assign restart   = reg_we && (reg_addr == RA_SIZE);
  assign ctrl_wr   = reg_we && (reg_addr == RA_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ring_base <= '0;
      size_lg   <= LG_W'(IDX_W);
      wr_idx    <= '0;
      max_len   <= 16'hFFFF;
      swap_en   <= 1'b0;
      wm_low    <= '0;
      wm_high   <= (IDX_W+1)'(1) << IDX_W;
    end else if (reg_we) begin
      case (reg_addr)
        RA_BASE:  ring_base <= reg_wdata;
        RA_SIZE: begin
          size_lg <= lg_wr;
          wr_idx  <= '0;
        end
        RA_WRIDX: wr_idx <= reg_wdata[IDX_W-1:0] & ring_mask;
        RA_CTRL: begin
          max_len <= reg_wdata[15:0];
          swap_en <= reg_wdata[16];
        end
        RA_WMARK: begin
          wm_low  <= reg_wdata[IDX_W:0];
          wm_high <= reg_wdata[16+IDX_W:16];
        end
        default: ;
      endcase
    end
  end

  AST_WR_IN_RING: assert property (@(posedge clk) disable iff (!rst_n) (wr_idx & ~ring_mask) == '0); // R1
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n) restart |=> (wr_idx == '0)); // R1

endmodule

// File: rtl/srcring_wmark.sv
module srcring_wmark
  import srcring_pkg::*;
#(
  parameter int unsigned IDX_W = 4
) (
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [IDX_W-1:0] ring_mask,
  input  logic [IDX_W:0]   wm_low,
  input  logic [IDX_W:0]   wm_high,
  output logic [IDX_W-1:0] free_slots,
  output logic             low_hit,
  output logic             high_hit
);

  logic [15:0] pend16;
  logic [15:0] room16;
  logic [IDX_W:0] pending;

  always_comb begin
    pend16  = ring_dist(16'(wr_idx), 16'(rd_idx), 16'(ring_mask));
    room16  = ring_room(16'(rd_idx), 16'(wr_idx), 16'(ring_mask));
    pending = {1'b0, pend16[IDX_W-1:0]};
    free_slots = room16[IDX_W-1:0];
    low_hit  = pending <= wm_low;
    high_hit = pending >= wm_high;
  end

  logic unused_hi;
  assign unused_hi = ^{pend16[15:IDX_W], room16[15:IDX_W]};

endmodule

// File: rtl/srcring_engine.sv
module srcring_engine
  import srcring_pkg::*;
#(
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned BEAT_LG = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [31:0]          ring_base,
  input  logic [IDX_W-1:0]     ring_mask,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [15:0]          max_len,
  input  logic                 swap_en,
  input  logic                 restart,
  input  logic                 ctrl_wr,
  output logic                 desc_rd_en,
  output logic [31:0]          desc_rd_addr,
  input  logic [63:0]          desc_rd_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [31:0]          out_addr,
  output logic [15:0]          out_bytes,
  output logic [16-BEAT_LG:0]  out_beats,
  output logic [ID_W-1:0]      out_id,
  output logic                 out_swap,
  output logic                 out_last,
  output logic                 done,
  output logic [15+IDX_W:0]    done_bytes,
  output logic [ID_W-1:0]      done_id,
  output logic [IDX_W-1:0]     rd_idx,
  output logic                 err_oversize
);

  localparam int unsigned SUM_W   = 16 + IDX_W;
  localparam int unsigned BEATS_W = 17 - BEAT_LG;

  eng_state_t       state;
  logic [IDX_W-1:0] fetch_idx;
  logic [IDX_W:0]   run_cnt;
  logic [SUM_W-1:0] acc_bytes;

  logic [31:0]      seg_addr;
  logic [15:0]      seg_bytes;
  logic [ID_W-1:0]  seg_id;
  logic             seg_swap;
  logic             seg_chain;
  logic             seg_over;

  desc_t d_in;
  assign d_in = desc_t'(desc_rd_data);

  // named events for the assertions
  logic fetch_go, seg_accept, seg_close, d_over;
  assign fetch_go   = (state == ST_IDLE) && (fetch_idx != wr_idx);
  assign seg_accept = (state == ST_SEND) && out_ready;
  assign seg_close  = seg_accept && !seg_chain;
  assign d_over     = d_in.nbytes > max_len;

  logic [15:0]      fetch16, rd16;
  logic [16:0]      beats17;
  logic [SUM_W-1:0] sum_nxt;

  always_comb begin
    fetch16 = ring_step(16'(fetch_idx), 16'd1, 16'(ring_mask));
    rd16    = ring_step(16'(rd_idx), 16'(run_cnt) + 16'd1, 16'(ring_mask));
    beats17 = beats_of(seg_bytes, BEAT_LG);
    sum_nxt = acc_bytes + SUM_W'(seg_bytes);
  end

  assign desc_rd_en   = fetch_go;
  assign desc_rd_addr = ring_base + (32'(fetch_idx) << DESC_LG);

  assign out_valid = (state == ST_SEND);
  assign out_addr  = seg_addr;
  assign out_bytes = seg_bytes;
  assign out_beats = beats17[BEATS_W-1:0];
  assign out_id    = seg_id;
  assign out_swap  = seg_swap;
  assign out_last  = !seg_chain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      fetch_idx  <= '0;
      rd_idx     <= '0;
      run_cnt    <= '0;
      acc_bytes  <= '0;
      done       <= 1'b0;
      done_bytes <= '0;
      done_id    <= '0;
      seg_addr   <= '0;
      seg_bytes  <= '0;
      seg_id     <= '0;
      seg_swap   <= 1'b0;
      seg_chain  <= 1'b0;
      seg_over   <= 1'b0;
    end else if (restart) begin
      state     <= ST_IDLE;
      fetch_idx <= '0;
      rd_idx    <= '0;
      run_cnt   <= '0;
      acc_bytes <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (fetch_go) state <= ST_WAIT;
        ST_WAIT: begin
          seg_addr  <= d_in.addr;
          seg_bytes <= d_over ? max_len : d_in.nbytes;
          seg_over  <= d_over;
          seg_chain <= d_in.flags[FLG_CHAIN];
          seg_swap  <= d_in.flags[FLG_SWAP] | swap_en;
          seg_id    <= d_in.flags[15:FLG_ID_LO];
          state     <= ST_SEND;
        end
        ST_SEND: if (out_ready) begin
          fetch_idx <= fetch16[IDX_W-1:0];
          state     <= ST_IDLE;
          if (seg_chain) begin
            run_cnt   <= run_cnt + 1'b1;
            acc_bytes <= sum_nxt;
          end else begin
            rd_idx     <= rd16[IDX_W-1:0];
            run_cnt    <= '0;
            acc_bytes  <= '0;
            done       <= 1'b1;
            done_bytes <= sum_nxt;
            done_id    <= seg_id;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      err_oversize <= 1'b0;
    else if (seg_accept && seg_over) err_oversize <= 1'b1;
    else if (ctrl_wr)                err_oversize <= 1'b0;
  end

  logic unused_hi;
  assign unused_hi = ^{fetch16[15:IDX_W], rd16[15:IDX_W], beats17[16:BEATS_W-1]};

  AST_SEG_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_ready && !restart) |=> (out_valid && $stable(out_addr) && $stable(out_bytes) && $stable(out_id) && $stable(out_last))); // R4
  AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n) desc_rd_en |=> !desc_rd_en); // R2
  AST_RD_ON_CLOSE: assert property (@(posedge clk) disable iff (!rst_n) !$stable(rd_idx) |-> ($past(seg_close) || $past(restart))); // R6
  AST_DONE_ON_CLOSE: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(seg_close)); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) ($past(err_oversize) && !$past(ctrl_wr)) |-> err_oversize); // R8

endmodule

// File: rtl/srcring_fetcher.sv
module srcring_fetcher
  import srcring_pkg::*;
#(
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned BEAT_LG = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [2:0]          reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic                desc_rd_en,
  output logic [31:0]         desc_rd_addr,
  input  logic [63:0]         desc_rd_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [31:0]         out_addr,
  output logic [15:0]         out_bytes,
  output logic [16-BEAT_LG:0] out_beats,
  output logic [ID_W-1:0]     out_id,
  output logic                out_swap,
  output logic                out_last,
  output logic                done,
  output logic [15+IDX_W:0]   done_bytes,
  output logic [ID_W-1:0]     done_id,
  output logic [IDX_W-1:0]    hw_rd_idx,
  output logic [IDX_W-1:0]    free_slots,
  output logic                wm_low_hit,
  output logic                wm_high_hit,
  output logic                err_oversize
);

  logic [31:0]      ring_base;
  logic [IDX_W-1:0] ring_mask;
  logic [IDX_W-1:0] wr_idx;
  logic [15:0]      max_len;
  logic             swap_en;
  logic [IDX_W:0]   wm_low, wm_high;
  logic             restart, ctrl_wr;

  srcring_regs #(.IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .ring_base(ring_base), .ring_mask(ring_mask), .wr_idx(wr_idx),
    .max_len(max_len), .swap_en(swap_en),
    .wm_low(wm_low), .wm_high(wm_high),
    .restart(restart), .ctrl_wr(ctrl_wr)
  );

  srcring_engine #(.IDX_W(IDX_W), .BEAT_LG(BEAT_LG)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .ring_base(ring_base), .ring_mask(ring_mask), .wr_idx(wr_idx),
    .max_len(max_len), .swap_en(swap_en),
    .restart(restart), .ctrl_wr(ctrl_wr),
    .desc_rd_en(desc_rd_en), .desc_rd_addr(desc_rd_addr), .desc_rd_data(desc_rd_data),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_bytes(out_bytes), .out_beats(out_beats),
    .out_id(out_id), .out_swap(out_swap), .out_last(out_last),
    .done(done), .done_bytes(done_bytes), .done_id(done_id),
    .rd_idx(hw_rd_idx), .err_oversize(err_oversize)
  );

  srcring_wmark #(.IDX_W(IDX_W)) u_wm (
    .wr_idx(wr_idx), .rd_idx(hw_rd_idx), .ring_mask(ring_mask),
    .wm_low(wm_low), .wm_high(wm_high),
    .free_slots(free_slots), .low_hit(wm_low_hit), .high_hit(wm_high_hit)
  );

endmodule

// File: tb/sim_srcring_fetcher.sv
`timescale 1ns/1ps
module sim_srcring_fetcher;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        desc_rd_en;
  logic [31:0] desc_rd_addr;
  logic [63:0] desc_rd_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_addr;
  logic [15:0] out_bytes;
  logic [13:0] out_beats;
  logic [13:0] out_id;
  logic        out_swap, out_last, done;
  logic [19:0] done_bytes;
  logic [13:0] done_id;
  logic [3:0]  hw_rd_idx, free_slots;
  logic        wm_low_hit, wm_high_hit, err_oversize;

  always #2 clk = ~clk;  // 250 MHz

  srcring_fetcher u0 (.*);

  logic [63:0] mem [0:63];
  always @(posedge clk) if (desc_rd_en) desc_rd_data <= mem[desc_rd_addr[8:3]];

  typedef struct {
    int addr; int bytes; int beats; int id;
    bit swap; bit last; bit over; int cnt; int total;
  } exp_t;
  exp_t q[$];

  int n_chk = 0, n_fail = 0, cyc = 0, rdy_mode = 0;
  int m_rd = 0, m_wr = 0, m_fetch = 0, m_mask = 15, m_base = 0;
  int m_max = 65535, m_low = 0, m_high = 16;
  bit m_swap = 0, m_err = 0, m_done = 0;
  int m_dbytes = 0, m_did = 0;
  int h_wr = 0, h_cnt = 0, h_total = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic cycle();
    exp_t e;
    bit nd, seterr;
    int ndb, ndi, pend;
    nd = 0; seterr = 0; ndb = 0; ndi = 0;
    case (rdy_mode)
      0: out_ready = 1'b1;
      1: out_ready = (cyc % 2) == 1;
      2: out_ready = (cyc % 3) != 0;
      default: out_ready = 1'b0;
    endcase
    if (desc_rd_en) begin
      chk(desc_rd_addr == 32'(m_base + 8*m_fetch), "R2 fetch address", desc_rd_addr, m_base + 8*m_fetch);
      chk(m_fetch != m_wr, "R2 fetch on empty ring", m_fetch, m_wr);
      m_fetch = (m_fetch + 1) & m_mask;
    end
    if (out_valid) begin
      if (q.size() == 0) chk(0, "R2 segment with nothing queued", 1, 0);
      else begin
        e = q[0];
        chk(out_addr == 32'(e.addr), "R3 address", out_addr, e.addr);
        chk(out_id == 14'(e.id), "R3 tag", out_id, e.id);
        chk(int'(out_bytes) == e.bytes, "R8 bytes", out_bytes, e.bytes);
        chk(int'(out_beats) == e.beats, "R4 beats", out_beats, e.beats);
        chk(out_swap == e.swap, "R9 swap", out_swap, e.swap);
        chk(out_last == e.last, "R5 last", out_last, e.last);
      end
    end
    if (out_valid && out_ready && q.size() > 0) begin
      e = q.pop_front();
      if (e.over) seterr = 1;
      if (e.last) begin
        nd = 1; ndb = e.total; ndi = e.id;
        m_rd = (m_rd + e.cnt) & m_mask;
      end
    end
    if (reg_we) begin
      case (reg_addr)
        3'd0: m_base = int'(reg_wdata);
        3'd1: begin
          m_mask = (1 << ((reg_wdata > 4) ? 4 : int'(reg_wdata))) - 1;
          m_rd = 0; m_wr = 0; m_fetch = 0; h_wr = 0;
        end
        3'd2: m_wr = int'(reg_wdata) & m_mask;
        3'd3: begin m_max = int'(reg_wdata[15:0]); m_swap = reg_wdata[16]; m_err = 0; end
        3'd4: begin m_low = int'(reg_wdata[4:0]); m_high = int'(reg_wdata[20:16]); end
        default: ;
      endcase
    end
    if (seterr) m_err = 1;
    @(negedge clk);
    cyc++;
    reg_we = 1'b0;
    m_done = nd; m_dbytes = ndb; m_did = ndi;
    chk(int'(hw_rd_idx) == m_rd, "R6 read index", hw_rd_idx, m_rd);
    chk(done == m_done, "R5 done pulse", done, m_done);
    if (m_done) begin
      chk(int'(done_bytes) == m_dbytes, "R5 done bytes", done_bytes, m_dbytes);
      chk(done_id == 14'(m_did), "R5 done tag", done_id, m_did);
    end
    chk(err_oversize == m_err, "R8 error flag", err_oversize, m_err);
    chk(int'(free_slots) == ((m_rd - m_wr - 1) & m_mask), "R7 free slots", free_slots, (m_rd - m_wr - 1) & m_mask);
    pend = (m_wr - m_rd) & m_mask;
    chk(wm_low_hit == (pend <= m_low), "R10 low mark", wm_low_hit, pend <= m_low);
    chk(wm_high_hit == (pend >= m_high), "R10 high mark", wm_high_hit, pend >= m_high);
  endtask

  task automatic wreg(input int a, input int d);
    reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = 32'(d);
    cycle();
  endtask

  task automatic push(input int addr, input int len, input int id, input bit chain, input bit dswap);
    exp_t e;
    int flags;
    flags = (id << 2) | (int'(dswap) << 1) | int'(chain);
    mem[(m_base >> 3) + h_wr] = {16'(flags), 16'(len), 32'(addr)};
    e.addr = addr; e.id = id; e.over = len > m_max;
    e.bytes = e.over ? m_max : len;
    e.beats = (e.bytes + 7) / 8;
    e.swap = dswap | m_swap; e.last = !chain;
    h_cnt++; h_total += e.bytes;
    e.cnt = h_cnt; e.total = h_total;
    if (e.last) begin h_cnt = 0; h_total = 0; end
    q.push_back(e);
    h_wr = (h_wr + 1) & m_mask;
  endtask

  task automatic drain();
    while (q.size() > 0) cycle();
    cycle(); cycle();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state, before any clock edge out of reset
    chk(hw_rd_idx == 4'd0, "R11 read index", hw_rd_idx, 0);
    chk(!out_valid && !done && !desc_rd_en, "R11 idle", {out_valid, done, desc_rd_en}, 0);
    chk(!err_oversize, "R11 error", err_oversize, 0);
    chk(free_slots == 4'd15, "R7 reset free", free_slots, 15);
    chk(wm_low_hit && !wm_high_hit, "R10 reset marks", {wm_low_hit, wm_high_hit}, 2);

    // single descriptors, always ready
    wreg(0, 32'h100);
    push(32'h1000_0040, 8, 5, 0, 0);
    push(32'h1000_0080, 13, 6, 0, 0);
    push(32'h1000_00C0, 0, 7, 0, 0);
    wreg(2, h_wr);
    drain();

    // chained run of four, ready every other cycle
    rdy_mode = 1;
    push(32'h2000_0000, 64, 20, 1, 0);
    push(32'h2000_1000, 17, 21, 1, 1);
    push(32'h2000_2000, 9, 22, 1, 0);
    push(32'h2000_3000, 100, 23, 0, 0);
    wreg(2, h_wr);
    drain();

    // oversize clamping and sticky error (R8), ring swap enable (R9)
    rdy_mode = 0;
    wreg(3, 100);
    push(32'h3000_0000, 300, 30, 0, 0);
    push(32'h3000_0100, 100, 31, 0, 0);
    wreg(2, h_wr);
    drain();
    chk(err_oversize, "R8 sticky after oversize", err_oversize, 1);
    wreg(3, 100 | (1 << 16));
    chk(!err_oversize, "R8 cleared by control write", err_oversize, 0);
    push(32'h3000_0200, 40, 32, 0, 0);
    wreg(2, h_wr);
    drain();
    wreg(3, 32'h0000_FFFF);

    // watermarks while the stream is stalled
    wreg(4, 1 | (3 << 16));
    rdy_mode = 3;
    for (int i = 0; i < 4; i++) push(32'h4000_0000 + i * 32'h40, 24, 40 + i, 0, 0);
    wreg(2, h_wr);
    repeat (8) cycle();
    chk(!wm_low_hit && wm_high_hit, "R10 stalled fill above high mark", {wm_low_hit, wm_high_hit}, 1);
    rdy_mode = 2;
    drain();
    wreg(4, 32'h0010_0000);

    // small ring of four entries: restart and wrap, with chained runs across the wrap
    wreg(1, 2);
    chk(hw_rd_idx == 4'd0 && free_slots == 4'd3, "R1 restart to four entries", {hw_rd_idx, free_slots}, 3);
    for (int r = 0; r < 4; r++) begin
      push(32'h5000_0000 + r * 32'h100, 16 + r, 50 + r, 1, 0);
      push(32'h5000_0040 + r * 32'h100, 5, 60 + r, 1, 0);
      push(32'h5000_0080 + r * 32'h100, 33, 70 + r, 0, r[0]);
      wreg(2, h_wr);
      chk(free_slots == 4'd0, "R7 one slot stays empty", free_slots, 0);
      drain();
    end
    chk(hw_rd_idx == 4'd0, "R6 read index after wrap", hw_rd_idx, 0);

    // size above the maximum clamps to 16 entries
    wreg(1, 9);
    chk(free_slots == 4'd15, "R1 clamped ring size", free_slots, 15);
    push(32'h6000_0000, 8, 90, 0, 0);
    wreg(2, h_wr);
    drain();

    summary();
  end

endmodule